// File: doc/BRIEF.md
# Shared-Coefficient Forward Elimination Unit

This block takes three point correspondences, one per cycle, and reduces the 3x3 coefficient matrix they form to upper-triangular form. Each source point (x, y) becomes a coefficient row (x, y, 1). The two target coordinates (u, v) are held beside that row as two right-hand-side columns. Both affine parameter systems use the same coefficient matrix, so the matrix is eliminated only once and both constant columns pass through the same row operations. A back-substitution stage downstream reads the reduced rows and solves for the six affine parameters.

All values are signed fixed point, 16 bits wide with 8 fractional bits by default. A single boundary cell forms each elimination factor in one cycle. It uses a reciprocal lookup table, indexed by the normalised mantissa of the pivot, and a shift set by the pivot's leading-one position. A row of internal multiply-subtract cells applies that factor to all five columns of the target row at once. The reduced rows are written back into the same row registers that the next step reads, so no separate intermediate buffer is needed. If any pivot is zero, the candidate is flagged as singular.

Top module: `fwd_elim_shared`

## Requirements
- R1: After reset, `busy`, `done` and `singular` are 0 and every bit of `outRows` is 0.
- R2: While `busy` is 0, each cycle with `inValid` high loads one row, in order rows 0, 1, 2. Row i holds columns (x, y, 1.0, u, v); the constant 1.0 is raw 256. Element (r, c) of `outRows` sits at bits [(r*5+c)*16 +: 16].
- R3: After the clock edge that loads row 2, `busy` is 1 for exactly three cycles. `done` is a one-cycle pulse that is high after the third edge following that load, in the same cycle in which `busy` returns to 0.
- R4: The factor for numerator a and pivot p is computed as follows. Let k be the leading-one position of |p|, and m the 6 bits of |p| just below that leading one (zero-filled). Let T = floor(2^18/(64+m)). The magnitude is (|a|*T) >> (k+4), saturated to 32767, and it is negated when the signs of a and p differ. A zero pivot gives a factor of 0.
- R5: Elimination runs three steps in this order: row 1 against row 0 at column 0, row 2 against row 0 at column 0, then row 2 against row 1 at column 1. Each column to the right of the pivot column becomes a - ((f*b) >>> 8), with results wrapped to 16 bits.
- R6: When `done` is high, elements (1,0), (2,0) and (2,1) are 0. Row 0 is unchanged from its loaded value.
- R7: The u and v columns are updated with the same factors as the coefficient columns.
- R8: `singular` is 1 at `done` if the pivot (0,0), the reduced pivot (1,1) or the final element (2,2) is zero. Loading a new row 0 clears it.
- R9: `inValid` pulses while `busy` is 1 are ignored and do not change the result.
- R10: `outRows` and `singular` hold their values after `done` until the next row is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | A point match is present on the data inputs |
| inX | input | 16 | Source x, Q8.8 |
| inY | input | 16 | Source y, Q8.8 |
| inU | input | 16 | Target u, Q8.8 |
| inV | input | 16 | Target v, Q8.8 |
| busy | output | 1 | Elimination in progress; loads are refused |
| done | output | 1 | One-cycle pulse when the reduced rows are valid |
| singular | output | 1 | A zero pivot was met in the current candidate |
| outRows | output | 240 | Reduced 3x5 matrix, row-major |

## Verification
A wrong step order, a wrong pivot selection or a bad table entry changes one or more of the fifteen elements that appear on `outRows` in the `done` cycle, three cycles after the last load. These errors cannot stay hidden past that cycle. A stuck or leaky sticky flag shows up as a wrong `singular` value in the same cycle, on a non-singular case that follows a singular one. A wrong step counter moves the `done` pulse or stretches `busy`, and both are visible at the ports within four cycles of the third load.

// File: rtl/fwd_elim_pkg.sv
package fwd_elim_pkg;
  localparam int N_ROWS = 3;
  localparam int N_COLS = 5;

  typedef struct packed {
    logic       loadEn;
    logic [1:0] loadRow;
    logic       elimEn;
    logic [1:0] elimStep;
  } strobe_t;
endpackage

// File: rtl/fe_recip_div.sv
module fe_recip_div #(
  parameter int DATA_W = 16,
  parameter int FRAC_W = 8,
  parameter int MANT_W = 6
) (
  input  logic signed [DATA_W-1:0] num,
  input  logic signed [DATA_W-1:0] piv,
  output logic signed [DATA_W-1:0] factor
);
  localparam int RECIP_FRAC = 12;
  localparam int TBL_W      = RECIP_FRAC + 1;
  localparam int LUT_N      = 1 << MANT_W;
  localparam int SHIFT0     = RECIP_FRAC - FRAC_W;
  localparam int PW         = DATA_W + 1 + TBL_W;
  localparam int KW         = $clog2(DATA_W + 1);
  localparam logic [PW-1:0] MAXPOS = PW'((1 << (DATA_W - 1)) - 1);

  logic [TBL_W-1:0] lut [LUT_N];
  for (genvar g = 0; g < LUT_N; g++) begin : gLut
    assign lut[g] = TBL_W'((1 << (RECIP_FRAC + MANT_W)) / ((1 << MANT_W) + g));
  end

  logic [DATA_W:0]        absNum, absPiv;
  logic [KW-1:0]          lead;
  logic [DATA_W+MANT_W:0] pivShift;
  logic [MANT_W-1:0]      mIdx;
  logic [PW-1:0]          prodMag, scaled, satMag;
  logic                   negRes;

  always_comb begin
    absNum = num[DATA_W-1] ? -{num[DATA_W-1], num} : {1'b0, num};
    absPiv = piv[DATA_W-1] ? -{piv[DATA_W-1], piv} : {1'b0, piv};
    lead = '0;
    for (int i = 0; i <= DATA_W; i++) begin
      if (absPiv[i]) lead = KW'(i);
    end
    pivShift = {absPiv, MANT_W'(0)} >> lead;
    mIdx     = pivShift[MANT_W-1:0];
    prodMag  = PW'(absNum) * PW'(lut[mIdx]);
    scaled   = prodMag >> (int'(lead) + SHIFT0);
    satMag   = (scaled > MAXPOS) ? MAXPOS : scaled;
    negRes   = num[DATA_W-1] ^ piv[DATA_W-1];
    if (piv == '0)   factor = '0;
    else if (negRes) factor = -DATA_W'(satMag);
    else             factor = DATA_W'(satMag);
  end
endmodule

// File: rtl/fe_mac_cell.sv
module fe_mac_cell #(
  parameter int DATA_W = 16,
  parameter int FRAC_W = 8
) (
  input  logic signed [DATA_W-1:0] acc,
  input  logic signed [DATA_W-1:0] factor,
  input  logic signed [DATA_W-1:0] pivVal,
  output logic signed [DATA_W-1:0] result
);
  logic signed [2*DATA_W-1:0] prod;
  logic signed [2*DATA_W-1:0] prodSh;
  always_comb begin
    prod   = factor * pivVal;
    prodSh = prod >>> FRAC_W;
    result = acc - DATA_W'(prodSh);
  end
endmodule

// File: rtl/fe_control.sv
module fe_control
  import fwd_elim_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  output strobe_t strobe,
  output logic    busy,
  output logic    done
);
  typedef enum logic {ST_IDLE, ST_ELIM} state_t;
  state_t     state;
  logic [1:0] rowCnt;
  logic [1:0] step;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      rowCnt <= '0;
      step   <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (inValid) begin
          if (rowCnt == 2'd2) begin
            rowCnt <= '0;
            step   <= '0;
            state  <= ST_ELIM;
          end else begin
            rowCnt <= rowCnt + 2'd1;
          end
        end
        ST_ELIM: begin
          step <= step + 2'd1;
          if (step == 2'd2) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.loadEn   = (state == ST_IDLE) && inValid;
    strobe.loadRow  = rowCnt;
    strobe.elimEn   = (state == ST_ELIM);
    strobe.elimStep = step;
    busy            = (state == ST_ELIM);
  end
endmodule

// File: rtl/fe_datapath.sv
module fe_datapath
  import fwd_elim_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int FRAC_W = 8,
  parameter int MANT_W = 6
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  strobe_t                          strobe,
  input  logic [DATA_W-1:0]                inX,
  input  logic [DATA_W-1:0]                inY,
  input  logic [DATA_W-1:0]                inU,
  input  logic [DATA_W-1:0]                inV,
  output logic                             singular,
  output logic [N_ROWS*N_COLS*DATA_W-1:0]  outRows
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1) << FRAC_W;

  logic signed [DATA_W-1:0] rows   [N_ROWS][N_COLS];
  logic signed [DATA_W-1:0] newVal [N_COLS];
  logic signed [DATA_W-1:0] piv, num, factor;
  int pivRow, tgtRow, pivCol;

  // step 0: r1 vs r0 @c0, step 1: r2 vs r0 @c0, step 2: r2 vs r1 @c1
  always_comb begin
    pivRow = (strobe.elimStep == 2'd2) ? 1 : 0;
    tgtRow = (strobe.elimStep == 2'd0) ? 1 : 2;
    pivCol = (strobe.elimStep == 2'd2) ? 1 : 0;
    piv    = rows[pivRow][pivCol];
    num    = rows[tgtRow][pivCol];
  end

  fe_recip_div #(.DATA_W(DATA_W), .FRAC_W(FRAC_W), .MANT_W(MANT_W)) uDiv (
    .num(num), .piv(piv), .factor(factor)
  );

  for (genvar j = 0; j < N_COLS; j++) begin : gCell
    fe_mac_cell #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) uCell (
      .acc(rows[tgtRow][j]), .factor(factor),
      .pivVal(rows[pivRow][j]), .result(newVal[j])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < N_ROWS; r++)
        for (int c = 0; c < N_COLS; c++) rows[r][c] <= '0;
      singular <= 1'b0;
    end else if (strobe.loadEn) begin
      rows[strobe.loadRow][0] <= inX;
      rows[strobe.loadRow][1] <= inY;
      rows[strobe.loadRow][2] <= ONE;
      rows[strobe.loadRow][3] <= inU;
      rows[strobe.loadRow][4] <= inV;
      if (strobe.loadRow == 2'd0) singular <= 1'b0;
    end else if (strobe.elimEn) begin
      for (int c = 0; c < N_COLS; c++) begin
        if (c > pivCol)       rows[tgtRow][c] <= newVal[c];
        else if (c == pivCol) rows[tgtRow][c] <= '0;
      end
      if (piv == '0) singular <= 1'b1;
      if (strobe.elimStep == 2'd2 && newVal[2] == '0) singular <= 1'b1;
    end
  end

  for (genvar r = 0; r < N_ROWS; r++) begin : gOutR
    for (genvar c = 0; c < N_COLS; c++) begin : gOutC
      assign outRows[(r*N_COLS+c)*DATA_W +: DATA_W] = rows[r][c];
    end
  end
endmodule

// File: rtl/fwd_elim_shared.sv
module fwd_elim_shared
  import fwd_elim_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int FRAC_W = 8,
  parameter int MANT_W = 6
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            inValid,
  input  logic [DATA_W-1:0]               inX,
  input  logic [DATA_W-1:0]               inY,
  input  logic [DATA_W-1:0]               inU,
  input  logic [DATA_W-1:0]               inV,
  output logic                            busy,
  output logic                            done,
  output logic                            singular,
  output logic [N_ROWS*N_COLS*DATA_W-1:0] outRows
);
  strobe_t strobe;

  fe_control uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .strobe(strobe), .busy(busy), .done(done)
  );

  fe_datapath #(.DATA_W(DATA_W), .FRAC_W(FRAC_W), .MANT_W(MANT_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .inX(inX), .inY(inY), .inU(inU), .inV(inV),
    .singular(singular), .outRows(outRows)
  );
endmodule

// File: rtl/fwd_elim_chk.sv
module fwd_elim_chk #(
  parameter int DATA_W = 16,
  parameter int OUT_W  = 240
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             busy,
  input logic             done,
  input logic             singular,
  input logic [OUT_W-1:0] outRows
);
  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R3
  done_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy && $past(busy, 1) && $past(busy, 2) && $past(busy, 3));

  // R6
  lower_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (outRows[5*DATA_W +: DATA_W] == '0) &&
             (outRows[10*DATA_W +: DATA_W] == '0) &&
             (outRows[11*DATA_W +: DATA_W] == '0));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !inValid) |=> $stable(outRows) && $stable(singular));
endmodule

bind fwd_elim_shared fwd_elim_chk #(.DATA_W(DATA_W), .OUT_W(15*DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .busy(busy),
  .done(done), .singular(singular), .outRows(outRows)
);

// File: tb/sim_fwd_elim_shared.sv
module sim_fwd_elim_shared;
  localparam int W = 16;
  localparam int OW = 15 * W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [W-1:0] inX = '0, inY = '0, inU = '0, inV = '0;
  logic busy, done, singular;
  logic [OW-1:0] outRows;

  int nChecks = 0;
  int nFails  = 0;

  typedef struct { logic [OW-1:0] rows; logic sing; string tag; } exp_t;
  exp_t expQ[$];
  logic [OW-1:0] lastRows;
  logic          lastSing;

  always #10 clk = ~clk;

  fwd_elim_shared u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .inX(inX), .inY(inY), .inU(inU), .inV(inV),
    .busy(busy), .done(done), .singular(singular), .outRows(outRows)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [OW-1:0] act, input logic [OW-1:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int w16(input int v);
    logic signed [15:0] t;
    t = v[15:0];
    return int'(t);
  endfunction

  // R4 factor from the stated reciprocal rule
  function automatic int refFactor(input int a, input int p);
    int ap, aa, k, m, t, mag;
    if (p == 0) return 0;
    ap = (p < 0) ? -p : p;
    aa = (a < 0) ? -a : a;
    k = 0;
    for (int i = 0; i < 17; i++) if ((ap >> i) & 1) k = i;
    m = ((ap << 6) >> k) & 63;
    t = (1 << 18) / (64 + m);
    mag = (aa * t) >> (k + 4);
    if (mag > 32767) mag = 32767;
    return ((a < 0) != (p < 0)) ? -mag : mag;
  endfunction

  // R5 element update
  function automatic int refUpd(input int a, input int f, input int b);
    return w16(a - ((f * b) >>> 8));
  endfunction

  task automatic runCase(input int xs[3], input int ys[3], input int us[3],
                         input int vs[3], input bit junk, input string tag);
    int m[3][5];
    int f;
    exp_t e;
    for (int r = 0; r < 3; r++) begin
      m[r][0] = w16(xs[r]); m[r][1] = w16(ys[r]); m[r][2] = 256;
      m[r][3] = w16(us[r]); m[r][4] = w16(vs[r]);
    end
    e.sing = (m[0][0] == 0);
    f = refFactor(m[1][0], m[0][0]);
    for (int c = 1; c < 5; c++) m[1][c] = refUpd(m[1][c], f, m[0][c]);
    m[1][0] = 0;
    f = refFactor(m[2][0], m[0][0]);
    for (int c = 1; c < 5; c++) m[2][c] = refUpd(m[2][c], f, m[0][c]);
    m[2][0] = 0;
    if (m[1][1] == 0) e.sing = 1'b1;
    f = refFactor(m[2][1], m[1][1]);
    for (int c = 2; c < 5; c++) m[2][c] = refUpd(m[2][c], f, m[1][c]);
    m[2][1] = 0;
    if (m[2][2] == 0) e.sing = 1'b1;
    for (int r = 0; r < 3; r++)
      for (int c = 0; c < 5; c++) e.rows[(r*5+c)*W +: W] = m[r][c][15:0];
    e.tag = tag;
    expQ.push_back(e);

    // R2 serial load of three rows
    for (int r = 0; r < 3; r++) begin
      @(negedge clk);
      inValid = 1'b1;
      inX = xs[r][15:0]; inY = ys[r][15:0]; inU = us[r][15:0]; inV = vs[r][15:0];
    end
    // R3 latency, R9 junk while busy
    for (int cyc = 1; cyc <= 4; cyc++) begin
      @(negedge clk);
      if (junk && cyc <= 3) begin
        inValid = 1'b1;
        inX = 16'h7123; inY = 16'h8456; inU = 16'h1111; inV = 16'h2222;
      end else begin
        inValid = 1'b0;
      end
      if (cyc <= 3)
        check(busy == 1'b1 && done == 1'b0, "R3", {tag, " busy window"},
              OW'({busy, done}), OW'(2'b10));
      else
        check(busy == 1'b0 && done == 1'b1, "R3", {tag, " done cycle"},
              OW'({busy, done}), OW'(2'b01));
    end
    @(negedge clk);
    inValid = 1'b0;
    check(done == 1'b0, "R3", {tag, " done single pulse"}, OW'(done), OW'(0));
    repeat (3) @(negedge clk);
    check(outRows == lastRows && singular == lastSing, "R10", {tag, " hold after done"},
          outRows, lastRows);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && done) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R3", "unexpected done", OW'(done), OW'(0));
        end else begin
          exp_t e;
          e = expQ.pop_front();
          check(outRows == e.rows, "R5 R7", {e.tag, " reduced rows"}, outRows, e.rows);
          check(singular == e.sing, "R8", {e.tag, " singular flag"},
                OW'(singular), OW'(e.sing));
          check(outRows[0 +: 5*W] == e.rows[0 +: 5*W], "R6", {e.tag, " row0 kept"},
                outRows[0 +: 5*W], e.rows[0 +: 5*W]);
          lastRows = e.rows;
          lastSing = e.sing;
        end
      end
    end
  end

  initial begin
    #4000000;
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy == 1'b0 && done == 1'b0 && singular == 1'b0 && outRows == '0,
          "R1", "reset state", outRows, '0);
    rstN = 1'b1;
    @(negedge clk);

    // general triangle, integer coordinates
    runCase('{256, 768, 1024}, '{512, 1280, 256}, '{300, -500, 1200},
            '{-800, 640, 90}, 1'b0, "caseA");
    // collinear points: reduced (1,1) pivot is zero
    runCase('{256, 512, 768}, '{256, 512, 768}, '{10, 20, 30},
            '{40, 50, 60}, 1'b0, "collinear");
    // negative and fractional, junk during busy (R9); singular clears (R8)
    runCase('{-384, 200, 1000}, '{100, -700, 333}, '{-1000, 77, 4000},
            '{512, -256, -3000}, 1'b1, "negFrac");
    // zero leading pivot
    runCase('{0, 256, 512}, '{256, 0, 768}, '{5, 6, 7},
            '{8, 9, 10}, 1'b0, "zeroPivot");
    // large spread, small pivots for the table
    runCase('{3, 5000, -7000}, '{-9000, 7, 40}, '{123, -456, 789},
            '{-321, 654, -987}, 1'b1, "spread");

    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R3", "all results seen", OW'(expQ.size()), OW'(0));
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule